// File: doc/BRIEF.md
# ADC External Start Qualifier

This block decides whether an asynchronous start pin may launch an analog-to-digital conversion. The pin is brought into the peripheral clock domain through a chain of synchronizing flops. Two stability filters then process it, one for level detection and one for edge detection. A two-bit condition field selects the kind of event that counts as a trigger: a low level, a high level, a falling edge or a rising edge. A qualified event sets the conversion-start flag. This is the same flag a software start sets, and it stays set until the conversion sequencer reports that the scan is finished.

Triggering needs three things at once: the enable is set, single-cycle scan mode is selected, and the trigger-source register holds the external-pin code. A small state machine controls when a trigger may be accepted. It has four states. `Q_OFF` means triggering is not allowed. `Q_REARM` waits for a level trigger to go inactive. `Q_ARMED` accepts a qualifying event. `Q_HOLD` means the start flag is set.

The transitions are:
- `Q_OFF -> Q_REARM` when triggering becomes allowed.
- `Q_REARM -> Q_ARMED` at once in an edge mode, or in a level mode once the filtered level is inactive.
- `Q_REARM -> Q_OFF` and `Q_ARMED -> Q_OFF` when triggering stops being allowed.
- Any other state `-> Q_HOLD` when the start flag is about to be set.
- `Q_HOLD -> Q_REARM` when the flag is about to clear.

Top module: `adc_ext_trig_qual`

## Requirements
- R1: After reset, `conv_start` is 0, `trig_armed` is 0 and `trig_src` is 2'b00.
- R2: In a level mode, `trig_cond` 2'b00 means active low and 2'b01 means active high. A pin held at its active level for at least LEVEL_HOLD clocks after synchronization sets `conv_start`.
- R3: In a level mode, an active level held for fewer than LEVEL_HOLD clocks does not set `conv_start`.
- R4: In an edge mode, `trig_cond` 2'b10 means falling and 2'b11 means rising. The pin must be stable for at least EDGE_HOLD clocks on the old level, then for at least EDGE_HOLD clocks on the new level. Such a transition sets `conv_start` exactly once.
- R5: In an edge mode, the following do not set `conv_start`: a pulse shorter than EDGE_HOLD clocks, and a transition of the opposite polarity.
- R6: While `scan_single` is 0 the pin is ignored.
- R7: While `trig_src` is not 2'b00 the pin is ignored.
- R8: A write on `src_wr` loads `src_wdata` into `trig_src` only when `trig_en` and `conv_start` are both 0. Otherwise the write is ignored.
- R9: `conv_start` clears in the clock after `seq_done` is seen high, unless `sw_start` is high in that clock. Pin events that occur while `conv_start` is set are ignored and do not start a later conversion.
- R10: In a level mode, after a conversion has completed, a level that is still held active does not retrigger. The level must first go inactive, then be held active again for the full filter time.
- R11: `sw_start` sets `conv_start` regardless of the trigger enable, the scan mode or the source.
- R12: `trig_armed` is 1 exactly when the qualifier is in `Q_ARMED`. It is never 1 while `conv_start` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_pin | input | 1 | Asynchronous external start pin |
| trig_en | input | 1 | External trigger enable |
| trig_cond | input | 2 | Trigger condition: 00 low level, 01 high level, 10 falling edge, 11 rising edge |
| scan_single | input | 1 | 1 when single-cycle scan mode is selected |
| src_wr | input | 1 | Write strobe for the trigger-source field |
| src_wdata | input | 2 | Value written to the trigger-source field |
| sw_start | input | 1 | Software start request |
| seq_done | input | 1 | Sequencer reports the scan is complete |
| conv_start | output | 1 | Conversion-start flag |
| trig_armed | output | 1 | Status: qualifier is ready to accept a pin event |
| trig_src | output | 2 | Current trigger-source field |

## Verification
The bench builds the block with its defaults: two synchronizer stages, LEVEL_HOLD of 8 and EDGE_HOLD of 4. With these values, short pulses of two or three clocks fall clearly inside each filter window, and full qualification completes within about fifteen clocks. This puts both the rejection of short glitches and the acceptance of held levels and edges within reach of short stimulus runs. The bench also covers all four condition codes, the re-arm rule for held levels, and the attempts to change the source while a trigger path is live.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    typedef enum logic [1:0] {
        Q_OFF   = 2'd0,
        Q_REARM = 2'd1,
        Q_ARMED = 2'd2,
        Q_HOLD  = 2'd3
    } qual_state_e;

    localparam logic [1:0] COND_LOW_LVL  = 2'b00;
    localparam logic [1:0] COND_HIGH_LVL = 2'b01;
    localparam logic [1:0] COND_FALL     = 2'b10;
    localparam logic [1:0] COND_RISE     = 2'b11;

    localparam logic [1:0] SRC_EXT_PIN   = 2'b00;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/trig_stab_filter.sv
module trig_stab_filter #(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic flt_o,
    output logic ok_o
);
    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             last_q;
    logic [CNT_W-1:0] run_q;
    logic             flt_q;
    logic             ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            run_q  <= '0;
            flt_q  <= 1'b0;
            ok_q   <= 1'b0;
        end else if (sync_i != last_q) begin
            last_q <= sync_i;
            run_q  <= CNT_ONE;
        end else begin
            if (run_q != CNT_MAX) run_q <= run_q + CNT_ONE;
            if (run_q == CNT_MAX) begin
                flt_q <= last_q;
                ok_q  <= 1'b1;
            end
        end
    end

    assign flt_o = flt_q;
    assign ok_o  = ok_q;

    // R3
    flt_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flt_q) |-> ($past(sync_i) == flt_q));
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic flt_i,
    input  logic ok_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_flt_q;
    logic prev_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_flt_q <= 1'b0;
            prev_ok_q  <= 1'b0;
        end else begin
            prev_flt_q <= flt_i;
            prev_ok_q  <= ok_i;
        end
    end

    assign rise_o = prev_ok_q & ok_i & ~prev_flt_q &  flt_i;
    assign fall_o = prev_ok_q & ok_i &  prev_flt_q & ~flt_i;

    // R4
    single_rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    // R4
    single_fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/trig_qual_fsm.sv
module trig_qual_fsm
    import adc_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic allow_i,
    input  logic lvl_mode_i,
    input  logic lvl_active_i,
    input  logic lvl_idle_i,
    input  logic edge_hit_i,
    input  logic start_q_i,
    input  logic start_nxt_i,
    output logic fire_o,
    output logic armed_o
);
    qual_state_e state_q;
    qual_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_OFF: begin
                if (start_nxt_i)  state_d = Q_HOLD;
                else if (allow_i) state_d = Q_REARM;
            end
            Q_REARM: begin
                if (start_nxt_i)                     state_d = Q_HOLD;
                else if (!allow_i)                   state_d = Q_OFF;
                else if (!lvl_mode_i || lvl_idle_i)  state_d = Q_ARMED;
            end
            Q_ARMED: begin
                if (start_nxt_i)   state_d = Q_HOLD;
                else if (!allow_i) state_d = Q_OFF;
            end
            Q_HOLD: begin
                if (!start_nxt_i) state_d = Q_REARM;
            end
            default: state_d = Q_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= Q_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        fire_o  = 1'b0;
        armed_o = 1'b0;
        unique case (state_q)
            Q_ARMED: begin
                armed_o = 1'b1;
                fire_o  = allow_i && !start_q_i &&
                          (lvl_mode_i ? lvl_active_i : edge_hit_i);
            end
            default: begin
                armed_o = 1'b0;
                fire_o  = 1'b0;
            end
        endcase
    end

    // R12
    armed_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |-> !start_q_i);
    // R10
    rearm_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == Q_REARM) && state_q == Q_ARMED && $past(lvl_mode_i))
            |-> $past(lvl_idle_i));
endmodule

// File: rtl/adc_ext_trig_qual.sv
module adc_ext_trig_qual
    import adc_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LEVEL_HOLD  = 8,
    parameter int EDGE_HOLD   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_pin,
    input  logic       trig_en,
    input  logic [1:0] trig_cond,
    input  logic       scan_single,
    input  logic       src_wr,
    input  logic [1:0] src_wdata,
    input  logic       sw_start,
    input  logic       seq_done,
    output logic       conv_start,
    output logic       trig_armed,
    output logic [1:0] trig_src
);
    logic       pin_sync;
    logic       lvl_flt, lvl_ok;
    logic       edg_flt, edg_ok;
    logic       edg_rise, edg_fall;
    logic       start_q, start_nxt;
    logic [1:0] src_q;
    logic       allow;
    logic       lvl_mode;
    logic       lvl_active, lvl_idle, edge_hit;
    logic       fire;

    trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (trig_pin),
        .sync_o  (pin_sync)
    );

    trig_stab_filter #(.HOLD(LEVEL_HOLD)) u_lvl_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (pin_sync),
        .flt_o  (lvl_flt),
        .ok_o   (lvl_ok)
    );

    trig_stab_filter #(.HOLD(EDGE_HOLD)) u_edg_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (pin_sync),
        .flt_o  (edg_flt),
        .ok_o   (edg_ok)
    );

    trig_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .flt_i  (edg_flt),
        .ok_i   (edg_ok),
        .rise_o (edg_rise),
        .fall_o (edg_fall)
    );

    always_comb begin
        allow      = trig_en && scan_single && (src_q == SRC_EXT_PIN);
        lvl_mode   = !trig_cond[1];
        lvl_active = lvl_ok && (lvl_flt == trig_cond[0]);
        lvl_idle   = lvl_ok && (lvl_flt != trig_cond[0]);
        edge_hit   = trig_cond[0] ? edg_rise : edg_fall;
    end

    trig_qual_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .allow_i      (allow),
        .lvl_mode_i   (lvl_mode),
        .lvl_active_i (lvl_active),
        .lvl_idle_i   (lvl_idle),
        .edge_hit_i   (edge_hit),
        .start_q_i    (start_q),
        .start_nxt_i  (start_nxt),
        .fire_o       (fire),
        .armed_o      (trig_armed)
    );

    assign start_nxt = fire || sw_start || (start_q && !seq_done);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            src_q   <= SRC_EXT_PIN;
        end else begin
            start_q <= start_nxt;
            if (src_wr && !trig_en && !start_q) src_q <= src_wdata;
        end
    end

    assign conv_start = start_q;
    assign trig_src   = src_q;

    // R6 R7
    hw_start_needs_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(start_q) && !$past(sw_start))
            |-> $past(trig_en && scan_single && (src_q == SRC_EXT_PIN)));
    // R8
    src_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(src_wr && (trig_en || start_q)) |-> $stable(src_q));
    // R9
    start_clears_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_q && seq_done && !sw_start) |-> !start_q);
    // R11
    sw_start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_start) |-> start_q);
endmodule

// File: tb/test_adc_ext_trig_qual.sv
module test_adc_ext_trig_qual;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_pin = 1'b1;
    logic       trig_en = 1'b0;
    logic [1:0] trig_cond = 2'b00;
    logic       scan_single = 1'b1;
    logic       src_wr = 1'b0;
    logic [1:0] src_wdata = 2'b00;
    logic       sw_start = 1'b0;
    logic       seq_done = 1'b0;
    logic       conv_start;
    logic       trig_armed;
    logic [1:0] trig_src;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_ext_trig_qual #(
        .SYNC_STAGES (2),
        .LEVEL_HOLD  (8),
        .EDGE_HOLD   (4)
    ) i_adc_ext_trig_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_pin    (trig_pin),
        .trig_en     (trig_en),
        .trig_cond   (trig_cond),
        .scan_single (scan_single),
        .src_wr      (src_wr),
        .src_wdata   (src_wdata),
        .sw_start    (sw_start),
        .seq_done    (seq_done),
        .conv_start  (conv_start),
        .trig_armed  (trig_armed),
        .trig_src    (trig_src)
    );

    typedef struct {
        string      id;
        int         kind;
        logic [1:0] val;
    } exp_t;

    exp_t exp_q[$];
    event smp;

    task automatic push(string id, int kind, logic [1:0] val);
        exp_t e;
        e.id = id; e.kind = kind; e.val = val;
        exp_q.push_back(e);
        -> smp;
    endtask

    task automatic exp_start(string id, logic v); push(id, 0, {1'b0, v}); endtask
    task automatic exp_armed(string id, logic v); push(id, 1, {1'b0, v}); endtask
    task automatic exp_src(string id, logic [1:0] v); push(id, 2, v); endtask

    initial begin
        forever begin
            @(smp);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [1:0] act;
                e = exp_q.pop_front();
                case (e.kind)
                    0:       act = {1'b0, conv_start};
                    1:       act = {1'b0, trig_armed};
                    default: act = trig_src;
                endcase
                n_vec++;
                if (act !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: actual %0d expected %0d", e.id, act, e.val);
                end
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_for(logic v, int n);
        trig_pin = v;
        wait_cyc(n);
    endtask

    task automatic write_src(logic [1:0] v);
        src_wr = 1'b1; src_wdata = v;
        wait_cyc(1);
        src_wr = 1'b0;
        wait_cyc(1);
    endtask

    task automatic done_pulse();
        seq_done = 1'b1;
        wait_cyc(1);
        seq_done = 1'b0;
        wait_cyc(1);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1
        exp_start("R1 reset start", 1'b0);
        exp_armed("R1 reset armed", 1'b0);
        exp_src("R1 reset src", 2'b00);

        // R8: write accepted while disabled and idle
        write_src(2'b01);
        exp_src("R8 write accepted", 2'b01);
        write_src(2'b00);
        exp_src("R8 write back", 2'b00);

        // R2 R3 active-high level
        trig_cond = 2'b01;
        trig_en = 1'b1;
        pin_for(1'b0, 25);
        exp_armed("R12 armed on idle level", 1'b1);
        exp_start("R12 no start while idle", 1'b0);
        pin_for(1'b1, 3);
        pin_for(1'b0, 25);
        exp_start("R3 short high level ignored", 1'b0);
        pin_for(1'b1, 25);
        exp_start("R2 high level triggers", 1'b1);
        exp_armed("R12 not armed while started", 1'b0);
        write_src(2'b10);
        exp_src("R8 write ignored while enabled", 2'b00);
        done_pulse();
        exp_start("R9 done clears start", 1'b0);
        wait_cyc(30);
        exp_start("R10 held level no retrigger", 1'b0);
        pin_for(1'b0, 25);
        pin_for(1'b1, 25);
        exp_start("R10 retrigger after deassert", 1'b1);
        done_pulse();

        // R2 active-low level
        trig_cond = 2'b00;
        pin_for(1'b1, 25);
        exp_start("R2 low-level idle", 1'b0);
        pin_for(1'b0, 25);
        exp_start("R2 low level triggers", 1'b1);
        done_pulse();
        pin_for(1'b1, 25);

        // R4 R5 rising edge
        trig_cond = 2'b11;
        pin_for(1'b0, 25);
        exp_start("R5 falling ignored in rise mode", 1'b0);
        pin_for(1'b1, 25);
        exp_start("R4 rising edge triggers", 1'b1);
        done_pulse();
        wait_cyc(20);
        exp_start("R4 one start per edge", 1'b0);
        pin_for(1'b0, 25);
        pin_for(1'b1, 2);
        pin_for(1'b0, 25);
        exp_start("R5 short pulse ignored", 1'b0);

        // R4 R9 falling edge, events during start ignored
        trig_cond = 2'b10;
        pin_for(1'b1, 25);
        exp_start("R5 rising ignored in fall mode", 1'b0);
        pin_for(1'b0, 25);
        exp_start("R4 falling edge triggers", 1'b1);
        pin_for(1'b1, 25);
        pin_for(1'b0, 25);
        exp_start("R9 start held during busy", 1'b1);
        done_pulse();
        wait_cyc(10);
        exp_start("R9 busy edge not replayed", 1'b0);

        // R6 not single scan
        scan_single = 1'b0;
        trig_cond = 2'b11;
        pin_for(1'b0, 25);
        pin_for(1'b1, 25);
        exp_start("R6 ignored outside single scan", 1'b0);
        exp_armed("R6 not armed outside single scan", 1'b0);
        scan_single = 1'b1;

        // R7 reserved source
        trig_en = 1'b0;
        wait_cyc(2);
        write_src(2'b01);
        exp_src("R8 write when disabled", 2'b01);
        trig_en = 1'b1;
        pin_for(1'b0, 25);
        pin_for(1'b1, 25);
        exp_start("R7 reserved source ignored", 1'b0);
        write_src(2'b00);
        exp_src("R8 write ignored while enabled", 2'b01);
        trig_en = 1'b0;
        wait_cyc(2);
        write_src(2'b00);

        // R11 software start
        sw_start = 1'b1;
        wait_cyc(1);
        sw_start = 1'b0;
        exp_start("R11 software start", 1'b1);
        write_src(2'b11);
        exp_src("R8 write ignored while started", 2'b00);
        done_pulse();
        exp_start("R9 clear after software start", 1'b0);

        wait_cyc(2);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule